// File: doc/BRIEF.md
# Start/Finish Ordering Monitor

A passive checker for a ring of N worker slots. Each slot reports a one-cycle start strobe and a one-cycle finish strobe. The monitor watches both vectors on every clock. It raises sticky error flags when the stream breaks either of two rules. The first rule is that starts and finishes alternate for each slot. The second is that starts rotate through the slots in strict ascending order, wrapping back to slot 0. The monitor never changes the stimulus.

For each slot the monitor keeps one bit of phase, recording whether a start or a finish is due next. For the whole ring it keeps the index of the slot that must start next. Alternation faults are reported per slot. Cyclic-order faults are reported on one flag. The lowest slot index involved in the first faulty cycle is latched so that the cause can be read after the fact. Finishes are not ordered against each other; only starts are.

Top module: `order_monitor`

## Requirements
- R1: After reset, every slot's phase expects a start, slot 0 is the expected next start, and `alt_err_o`, `order_err_o` and `first_err_vld_o` are all 0.
- R2: A start on slot i, without a finish on slot i in the same cycle, while slot i is waiting for its finish sets `alt_err_o[i]` on the next clock edge.
- R3: A finish on slot i, without a start on slot i in the same cycle, while slot i expects a start (including before its first start) sets `alt_err_o[i]` on the next clock edge.
- R4: Exactly one start in a cycle, on a slot other than the expected slot, sets `order_err_o` on the next clock edge. A start on the expected slot does not.
- R5: After a single start on slot i, the expected slot becomes i+1, and slot N-1 is followed by slot 0.
- R6: Starts on two or more slots in the same cycle set `order_err_o` and leave the expected slot unchanged. Each of those starts still advances its own slot's phase.
- R7: A start and a finish on the same slot in the same cycle set `order_err_o`, do not set that slot's `alt_err_o` bit, and leave that slot's phase unchanged. For ring ordering they count as a start.
- R8: Finishes on different slots may come in any order and in the same cycle without raising any flag, provided each follows its own start.
- R9: Every error flag stays set until `rst_ni` is asserted, whatever the later traffic.
- R10: In the first cycle that contains any fault, `first_err_vld_o` rises and `first_err_idx_o` latches the lowest index of the slots involved. Later faults change neither output.
- R11: After a single out-of-order start on slot j, the expected slot becomes j+1. The ring order re-synchronises to the observed start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | N_UNITS | Per-slot start strobe |
| finish_i | input | N_UNITS | Per-slot finish strobe |
| alt_err_o | output | N_UNITS | Sticky per-slot alternation fault |
| order_err_o | output | 1 | Sticky cyclic-order fault |
| first_err_vld_o | output | 1 | A fault has been latched |
| first_err_idx_o | output | IDX_W | Lowest slot involved in the first fault |

## Verification
A wrong per-slot phase bit shows up as a spurious or missing `alt_err_o` bit on the edge that follows the next strobe on that slot. A wrong expected-slot register shows up as a spurious or missing `order_err_o` on the edge after the next single start. The bench sweeps every combination of start and finish vectors from a fresh state and from a state where all slots are busy. It also drives legal rotations with shuffled finishes and a long pseudo-random stream, and compares every flag and the latched index on every cycle against an arithmetic model of the rules.

// File: rtl/om_pkg.sv
package om_pkg;
  typedef enum logic {
    PH_START  = 1'b0,
    PH_FINISH = 1'b1
  } phase_e;
endpackage

// File: rtl/om_alt_cell.sv
module om_alt_cell
  import om_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic finish_i,
  output logic alt_evt_o,
  output logic alt_err_o
);
  phase_e phase_q;
  logic   err_q;
  logic   collide;

  always_comb begin
    collide   = start_i & finish_i;
    alt_evt_o = !collide &&
                ((start_i && phase_q == PH_FINISH) || (finish_i && phase_q == PH_START));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_START;
      err_q   <= 1'b0;
    end else begin
      if (!collide) begin
        if (start_i)       phase_q <= PH_FINISH;
        else if (finish_i) phase_q <= PH_START;
      end
      err_q <= err_q | alt_evt_o;
    end
  end

  assign alt_err_o = err_q;

  assert_alt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_collide_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> $stable(phase_q));
  assert_restart_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !finish_i && phase_q == PH_FINISH) |=> err_q);
  assert_early_finish_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_i && !start_i && phase_q == PH_START) |=> err_q);
endmodule

// File: rtl/om_succ.sv
module om_succ #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] start_i,
  input  logic [N_UNITS-1:0] finish_i,
  output logic [N_UNITS-1:0] ord_mask_o,
  output logic               order_err_o
);
  logic [IDX_W-1:0] exp_q;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W:0]   cnt;
  logic             multi, single;
  logic             err_q;

  always_comb begin
    cnt     = '0;
    hit_idx = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (start_i[i]) begin
        cnt     = cnt + 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
    multi  = cnt > (IDX_W+1)'(1);
    single = cnt == (IDX_W+1)'(1);
    for (int i = 0; i < N_UNITS; i++) begin
      ord_mask_o[i] = (start_i[i] & finish_i[i]) |
                      (start_i[i] & (multi | (IDX_W'(i) != exp_q)));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (single) exp_q <= (hit_idx == IDX_W'(N_UNITS-1)) ? '0 : hit_idx + 1'b1;
      err_q <= err_q | (|ord_mask_o);
    end
  end

  assign order_err_o = err_q;

  assert_order_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  assert_multi_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi |=> ($stable(exp_q) && err_q));
  assert_succ_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && start_i[N_UNITS-1]) |=> (exp_q == '0));
  assert_succ_next_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single && start_i[0]) |=> (exp_q == IDX_W'(1)));
endmodule

// File: rtl/om_first_err.sv
module om_first_err #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] evt_mask_i,
  output logic               vld_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] low;

  always_comb begin
    low = '0;
    for (int i = N_UNITS-1; i >= 0; i--) begin
      if (evt_mask_i[i]) low = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (!vld_q && (|evt_mask_i)) begin
      vld_q <= 1'b1;
      idx_q <= low;
    end
  end

  assign vld_o = vld_q;
  assign idx_o = idx_q;

  assert_first_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> (vld_q && $stable(idx_q)));
endmodule

// File: rtl/order_monitor.sv
module order_monitor #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_UNITS-1:0] start_i,
  input  logic [N_UNITS-1:0] finish_i,
  output logic [N_UNITS-1:0] alt_err_o,
  output logic               order_err_o,
  output logic               first_err_vld_o,
  output logic [IDX_W-1:0]   first_err_idx_o
);
  logic [N_UNITS-1:0] alt_evt;
  logic [N_UNITS-1:0] ord_mask;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_cell
    om_alt_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i[g]),
      .finish_i  (finish_i[g]),
      .alt_evt_o (alt_evt[g]),
      .alt_err_o (alt_err_o[g])
    );
  end

  om_succ #(.N_UNITS(N_UNITS)) i_succ (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .finish_i    (finish_i),
    .ord_mask_o  (ord_mask),
    .order_err_o (order_err_o)
  );

  om_first_err #(.N_UNITS(N_UNITS)) i_first (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_mask_i (alt_evt | ord_mask),
    .vld_o      (first_err_vld_o),
    .idx_o      (first_err_idx_o)
  );

  assert_first_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(first_err_vld_o) |-> ((|alt_err_o) || order_err_o));
  assert_flags_need_vld_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|alt_err_o) || order_err_o) |-> first_err_vld_o);
endmodule

// File: tb/test_order_monitor.sv
module test_order_monitor;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  start = '0, finish = '0;
  logic [N-1:0]  alt_err;
  logic          order_err, vld;
  logic [IW-1:0] idx;

  int total = 0, bad = 0;
  bit [N-1:0] m_pend, m_alt;
  bit m_ord, m_vld;
  int m_exp, m_idx;

  always #10 clk = ~clk;

  order_monitor #(.N_UNITS(N)) i_order_monitor (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .finish_i(finish),
    .alt_err_o(alt_err), .order_err_o(order_err),
    .first_err_vld_o(vld), .first_err_idx_o(idx)
  );

  task automatic chk(input bit ok, input string tag, input string ctx, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic compare(input string ctx);
    chk(alt_err == m_alt, "R2/R3 alt flags", ctx, int'(alt_err), int'(m_alt));
    chk(order_err == m_ord, "R4 order flag", ctx, int'(order_err), int'(m_ord));
    chk(vld == m_vld, "R10 first valid", ctx, int'(vld), int'(m_vld));
    if (m_vld) chk(int'(idx) == m_idx, "R10 first index", ctx, int'(idx), m_idx);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    start = '0; finish = '0; rst_n = 1'b0;
    #25; rst_n = 1'b1;
    m_pend = '0; m_alt = '0; m_ord = 0; m_vld = 0; m_exp = 0; m_idx = 0;
    @(posedge clk); #1;
    compare("R1 reset state");
  endtask

  // Model of R2..R11; outputs checked one edge after the strobes.
  task automatic step(input logic [N-1:0] s, input logic [N-1:0] f, input string ctx);
    int ns = 0, lastj = 0;
    bit [N-1:0] mask = '0;
    bit ord = 0;
    start = s; finish = f;
    for (int j = 0; j < N; j++) if (s[j]) begin ns++; lastj = j; end
    for (int j = 0; j < N; j++) begin
      if (s[j] && f[j]) begin
        mask[j] = 1; ord = 1;                       // R7
      end else begin
        if ((s[j] && m_pend[j]) || (f[j] && !m_pend[j])) begin
          m_alt[j] = 1; mask[j] = 1;                // R2, R3
        end
        if (s[j]) m_pend[j] = 1;
        else if (f[j]) m_pend[j] = 0;
      end
    end
    if (ns > 1) begin                               // R6
      ord = 1;
      for (int j = 0; j < N; j++) if (s[j]) mask[j] = 1;
    end
    if (ns == 1) begin                              // R4, R5, R11
      if (lastj != m_exp) begin ord = 1; mask[lastj] = 1; end
      m_exp = (lastj + 1) % N;
    end
    m_ord = m_ord | ord;                            // R9
    if (!m_vld && mask != 0) begin                  // R10
      m_vld = 1;
      for (int j = N-1; j >= 0; j--) if (mask[j]) m_idx = j;
    end
    @(posedge clk); #1;
    start = '0; finish = '0;
    compare(ctx);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    do_reset();

    // R2 R3 R4 R6 R7: every start/finish combination from the reset state
    for (int v = 0; v < 256; v++) begin
      do_reset();
      step(v[3:0], v[7:4], "sweep fresh R2 R3 R4 R6 R7");
    end

    // same sweep with every slot busy, expected slot back at 0
    for (int v = 0; v < 256; v++) begin
      do_reset();
      for (int k = 0; k < N; k++) step(4'(1 << k), 4'h0, "prime R5");
      step(v[3:0], v[7:4], "sweep busy R2 R3 R4 R6 R7");
    end

    // R5 R8: legal rotations with shuffled and simultaneous finishes
    do_reset();
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < N; k++) step(4'(1 << k), 4'h0, "rotation R5");
      step(4'h0, 4'b0100, "finish order R8");
      step(4'h0, 4'b1001, "joint finish R8");
      step(4'h0, 4'b0010, "finish order R8");
    end

    // R9 R10 R11: early finish, then wrong start, then legal traffic
    do_reset();
    step(4'h0, 4'b0010, "early finish R3");
    step(4'b0100, 4'h0, "wrong start R11");
    step(4'b1000, 4'h0, "resync start R11");
    step(4'b0001, 4'h0, "resync wrap R5");
    for (int k = 0; k < 6; k++) step(4'h0, 4'h0, "sticky idle R9");

    // R10: lowest index of a multi-slot first fault
    do_reset();
    step(4'b1010, 4'h0, "multi start R6 R10");
    step(4'b0001, 4'b0001, "later collide R7 R10");

    // mixed pseudo-random stream
    do_reset();
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c % 300 == 299) do_reset();
      else step(lfsr[3:0] & lfsr[7:4] & lfsr[11:8],
                lfsr[15:12] & lfsr[11:8] & lfsr[6:3], "stream R2 R3 R4 R8 R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule